// File: doc/BRIEF.md
# Center-Aligned Pulse-Width Modulation Channel

This block produces one pulse-width modulated output whose pulses sit symmetrically about the middle of each output cycle. An internal 8-bit counter climbs from zero to the active period value and then falls back to zero. The output flip-flop inverts each time the counter meets the active duty value, once on the way up and once on the way down. Counting advances only in cycles where an external prescaler asserts a clock-enable tick.

Software writes period and duty values into holding registers through simple write strobes. The active copies that steer the waveform are taken from the holding registers at two points only: when the channel is enabled, and when the falling count reaches zero. The output polarity is sampled at those same points. Software should therefore set up a channel before it enables it. When the channel is disabled, the counter is held at zero and the output follows the polarity input.

Top module: `center_pwm`

## Requirements
- R1: While reset is asserted the output is 0. Reset clears the holding registers, so a channel enabled without any write acts as period 0 with duty 0 (see R6).
- R2: With active period P > 0 and a tick every cycle, the waveform repeats every 2·P ticks. The counter visits 0, 1, …, P, P−1, …, 1 and then returns to 0, where it reloads.
- R3: With active duty D where 0 < D < P, and tick index k counted from the load (k = 0 is the load cycle), the output equals the start level for k mod 2P < D and for k mod 2P > 2P−D−1. It is inverted from the start level in between. The start level equals the polarity bit sampled at the load.
- R4: Within one output cycle, the high time is 2·min(D,P) ticks with polarity 1 and 2P − 2·min(D,P) ticks with polarity 0.
- R5: When D = 0 the output holds the inverse of the sampled polarity for the whole cycle. When D ≥ P it holds the sampled polarity. In neither case does it toggle.
- R6: With an active period of 0 the counter stays at zero and the output stays at the static level given by R5. Each tick performs a reload.
- R7: A period or duty write while the channel runs has no effect on the output until the next reload. That reload happens when the falling count reaches zero.
- R8: A change of the polarity input while the channel runs has no effect on the output until the next reload.
- R9: In cycles without a tick, neither the counter nor the output changes while the channel is enabled.
- R10: While the enable is low, the output equals the polarity input one cycle later. The first clock edge that sees the enable high reloads at once: the output shows tick index 0 of R3 and R5, without waiting for a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Clock-enable tick from the prescaler |
| chanEn | input | 1 | Channel enable |
| polarity | input | 1 | Output polarity, sampled at each reload |
| perWr | input | 1 | Write strobe for the period holding register |
| perIn | input | 8 | Period value to write |
| dutyWr | input | 1 | Write strobe for the duty holding register |
| dutyIn | input | 8 | Duty value to write |
| pwmOut | output | 1 | Modulated output |

## Verification
Several properties are checked by assertions on every cycle. The counter never goes above the active period and moves by exactly one count per tick. The direction is always up at zero. The active period changes only together with a zero count. The output and the counter stay still in cycles without a tick, and a disabled channel shows the polarity input. The bench shows what only complete scenarios reveal. It sweeps the exact tick-by-tick waveform over every period from 0 to 6, every duty from 0 to 7 and both polarities, across two cycles each. It also shows the deferral of buffered writes and of polarity changes to the next reload, the static levels of the corner cases, and the immediate reload on enable.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  // strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic hold;      // channel off: park the counter and output
    logic load;      // copy the holding registers to the active set
    logic stepUp;    // increment the counter
    logic stepDown;  // decrement the counter
  } cpwmCtl_t;

  // counter conditions reported back to the control
  typedef struct packed {
    logic atPeak;    // counter equals active period
    logic atOne;     // counter equals one
    logic perZero;   // active period is zero
  } cpwmStat_t;

endpackage

// File: rtl/cpwm_ctrl.sv
module cpwm_ctrl
  import cpwm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      chanEn,
  input  cpwmStat_t stat,
  output cpwmCtl_t  ctl,
  output logic      dirDown,
  output logic      enPrev
);

  logic running;
  logic turnAround;
  logic wrapZero;

  always_comb begin
    running    = chanEn && enPrev;
    turnAround = !dirDown && stat.atPeak;
    // the next decrement lands on zero
    wrapZero   = stat.atOne && (dirDown || turnAround);

    ctl.hold     = !chanEn;
    ctl.load     = chanEn && (!enPrev || (tickEn && (stat.perZero || wrapZero)));
    ctl.stepUp   = running && tickEn && !stat.perZero && !dirDown && !stat.atPeak;
    ctl.stepDown = running && tickEn && !stat.perZero && !wrapZero
                   && (dirDown || stat.atPeak);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirDown <= 1'b0;
      enPrev  <= 1'b0;
    end else begin
      enPrev <= chanEn;
      if (ctl.hold || ctl.load) begin
        dirDown <= 1'b0;
      end else if (ctl.stepDown) begin
        dirDown <= 1'b1;
      end else if (ctl.stepUp) begin
        dirDown <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cpwm_datapath.sv
module cpwm_datapath
  import cpwm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cpwmCtl_t         ctl,
  input  logic             polarity,
  input  logic             perWr,
  input  logic [WIDTH-1:0] perIn,
  input  logic             dutyWr,
  input  logic [WIDTH-1:0] dutyIn,
  output cpwmStat_t        stat,
  output logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] perAct,
  output logic             pwmOut
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] perBuf;
  logic [WIDTH-1:0] dutyBuf;
  logic [WIDTH-1:0] dutyAct;
  logic [WIDTH-1:0] nextCnt;
  logic             toggleOk;
  logic             dutyHit;
  logic             startLvl;

  always_comb begin
    stat.atPeak  = (cnt == perAct);
    stat.atOne   = (cnt == ONE);
    stat.perZero = (perAct == ZERO);
    nextCnt      = ctl.stepUp ? cnt + ONE : cnt - ONE;
    toggleOk     = (dutyAct != ZERO) && (dutyAct < perAct);
    dutyHit      = toggleOk && (nextCnt == dutyAct);
    // a zero duty parks the output at the inverse level for the whole cycle
    startLvl     = (dutyBuf == ZERO) ? ~polarity : polarity;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perBuf  <= ZERO;
      dutyBuf <= ZERO;
      perAct  <= ZERO;
      dutyAct <= ZERO;
      cnt     <= ZERO;
      pwmOut  <= 1'b0;
    end else begin
      if (perWr)  perBuf  <= perIn;
      if (dutyWr) dutyBuf <= dutyIn;
      if (ctl.hold) begin
        cnt    <= ZERO;
        pwmOut <= polarity;
      end else if (ctl.load) begin
        perAct  <= perBuf;
        dutyAct <= dutyBuf;
        cnt     <= ZERO;
        pwmOut  <= startLvl;
      end else if (ctl.stepUp || ctl.stepDown) begin
        cnt <= nextCnt;
        if (dutyHit) pwmOut <= ~pwmOut;
      end
    end
  end

endmodule

// File: rtl/center_pwm.sv
module center_pwm
  import cpwm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             chanEn,
  input  logic             polarity,
  input  logic             perWr,
  input  logic [WIDTH-1:0] perIn,
  input  logic             dutyWr,
  input  logic [WIDTH-1:0] dutyIn,
  output logic             pwmOut
);

  cpwmCtl_t         ctl;
  cpwmStat_t        stat;
  logic             dirDown;
  logic             enPrev;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] perAct;

  cpwm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .chanEn  (chanEn),
    .stat    (stat),
    .ctl     (ctl),
    .dirDown (dirDown),
    .enPrev  (enPrev)
  );

  cpwm_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .polarity (polarity),
    .perWr    (perWr),
    .perIn    (perIn),
    .dutyWr   (dutyWr),
    .dutyIn   (dutyIn),
    .stat     (stat),
    .cnt      (cnt),
    .perAct   (perAct),
    .pwmOut   (pwmOut)
  );

endmodule

// File: rtl/cpwm_checker.sv
module cpwm_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             chanEn,
  input logic             polarity,
  input logic             pwmOut,
  input logic             dirDown,
  input logic             enPrev,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] perAct
);

  // R2: the count never passes the active period
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= perAct);

  // R2: a running tick moves the count by exactly one
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && enPrev && tickEn && perAct != '0) |=>
      ((WIDTH'(cnt - $past(cnt)) == WIDTH'(1)) ||
       (WIDTH'($past(cnt) - cnt) == WIDTH'(1))));

  // R2: direction is up whenever the count sits at zero
  p_up_at_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0) |-> !dirDown);

  // R7: the active period only changes together with a zero count
  p_period_at_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (perAct != $past(perAct)) |-> (cnt == '0));

  // R9: no tick, no movement
  p_no_tick_still_r9: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && enPrev && !tickEn) |=> ($stable(cnt) && $stable(pwmOut)));

  // R10: disabled channel shows the polarity input
  p_idle_level_r10: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> (pwmOut == $past(polarity)));

endmodule

bind center_pwm cpwm_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .chanEn   (chanEn),
  .polarity (polarity),
  .pwmOut   (pwmOut),
  .dirDown  (dirDown),
  .enPrev   (enPrev),
  .cnt      (cnt),
  .perAct   (perAct)
);

// File: tb/center_pwm_test.sv
`timescale 1ns/1ps
module center_pwm_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       chanEn = 1'b0;
  logic       polarity = 1'b0;
  logic       perWr = 1'b0;
  logic [7:0] perIn = '0;
  logic       dutyWr = 1'b0;
  logic [7:0] dutyIn = '0;
  logic       pwmOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  center_pwm uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .chanEn(chanEn),
    .polarity(polarity), .perWr(perWr), .perIn(perIn),
    .dutyWr(dutyWr), .dutyIn(dutyIn), .pwmOut(pwmOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected level at tick index k after a load
  function automatic int expLvl(int p, int d, int pol, int k);
    int kk;
    int start;
    int inv;
    start = (d == 0) ? 1 - pol : pol;
    if (p == 0) return start;
    kk  = k % (2 * p);
    inv = (d > 0 && d < p && kk >= d && kk <= 2 * p - d - 1) ? 1 : 0;
    return start ^ inv;
  endfunction

  task automatic writeBuf(input int p, input int d);
    tickEn = 1'b0;
    perWr = 1'b1; perIn = 8'(p);
    dutyWr = 1'b1; dutyIn = 8'(d);
    @(negedge clk);
    perWr = 1'b0; dutyWr = 1'b0;
  endtask

  // one tick, then (div-1) idle cycles with the output required to stay
  task automatic tickOnce(input int div, input string req, input int exp);
    int held;
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    check(req, int'(pwmOut), exp);
    held = int'(pwmOut);
    for (int i = 1; i < div; i++) begin
      @(negedge clk);
      check("R9", int'(pwmOut), held);
    end
  endtask

  // disable, optionally program, then enable; returns at the sample of k=0
  task automatic startRun(input int p, input int d, input int pol, input bit doWr);
    chanEn = 1'b0; tickEn = 1'b0; polarity = pol[0];
    @(negedge clk);
    if (doWr) writeBuf(p, d);
    chanEn = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int highs;
    int nSamp;
    repeat (3) @(negedge clk);
    check("R1 reset output", int'(pwmOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: no writes since reset acts as period 0, duty 0
    startRun(0, 0, 1, 1'b0);
    check("R1 cleared buffers pol1", int'(pwmOut), 0);
    tickOnce(1, "R1 cleared buffers pol1", 0);
    startRun(0, 0, 0, 1'b0);
    check("R1 cleared buffers pol0", int'(pwmOut), 1);

    // sweep: R2 R3 R5 R6 R10 waveform shape, R4 high time
    for (int p = 0; p <= 6; p++) begin
      for (int d = 0; d <= 7; d++) begin
        for (int pol = 0; pol <= 1; pol++) begin
          startRun(p, d, pol, 1'b1);
          check("R10 load on enable", int'(pwmOut), expLvl(p, d, pol, 0));
          highs = int'(pwmOut);
          nSamp = (p == 0) ? 6 : 4 * p;
          for (int k = 1; k < nSamp; k++) begin
            tickOnce(1, (p == 0) ? "R6" : ((d > 0 && d < p) ? "R3" : "R5"),
                     expLvl(p, d, pol, k));
            if (k < 2 * p) highs += int'(pwmOut);
          end
          if (p > 0)
            check("R4 high ticks per cycle", highs,
                  (pol == 1) ? 2 * ((d < p) ? d : p) : 2 * p - 2 * ((d < p) ? d : p));
        end
      end
    end

    // R9: sparse ticks, output frozen between them
    startRun(3, 1, 1, 1'b1);
    for (int k = 1; k < 12; k++) tickOnce(3, "R9 gated waveform", expLvl(3, 1, 1, k));

    // R7 and R8: new duty and polarity wait for the reload at zero
    startRun(4, 1, 1, 1'b1);
    tickOnce(1, "R2", expLvl(4, 1, 1, 1));
    tickOnce(1, "R2", expLvl(4, 1, 1, 2));
    writeBuf(4, 3);
    polarity = 1'b0;
    for (int k = 3; k < 8; k++) tickOnce(1, "R7 R8 old values kept", expLvl(4, 1, 1, k));
    for (int k = 8; k < 16; k++) tickOnce(1, "R7 R8 new values", expLvl(4, 3, 0, k));

    // R10: disabled output follows polarity input
    chanEn = 1'b0; polarity = 1'b1;
    @(negedge clk);
    check("R10 idle level pol1", int'(pwmOut), 1);
    polarity = 1'b0;
    @(negedge clk);
    check("R10 idle level pol0", int'(pwmOut), 0);
    tickOnce(1, "R10 idle ignores tick", 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule